// File: doc/BRIEF.md
# Masked Vector Carry-Less Multiplier

This block runs the vector carry-less multiply instructions on a short vector of elements. A 32-bit instruction word arrives with two packed source vectors, one scalar register value, a per-element mask, an active length and the old destination vector. A decoder picks out the low-half and high-half product variants, each in a vector-vector form and a vector-scalar form. Each element that is active takes its first operand from the vs2 vector. Its second operand comes from the vs1 vector or from the scalar, which is broadcast to every element. The block forms the 2*SEW-bit XOR product of the two operands and keeps either its lower or its upper SEW bits.

All lanes work combinationally in a single cycle. The results then pass through one output register with a valid/ready handshake. An input is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds steady and no new input is taken. Element i sits in bits [i*SEW +: SEW] of every packed vector. Elements that are masked off, and elements at or past the active length, return their old destination value unchanged with their write strobe clear.

Top module: `vclmul_unit`

## Requirements
- R1: An instruction is legal only when bits [6:0] equal 1010111, bits [31:26] equal 001100 (low half) or 001101 (high half), and bits [14:12] equal 010 (vector-vector) or 110 (vector-scalar); bit 25 is the mask-enable bit vm.
- R2: The low-half result of an element is the XOR of (other operand << n) over every set bit n of the vs2 element, truncated to SEW bits.
- R3: The high-half result of an element is the XOR of (other operand >> (SEW-n)) over every set bit n of the vs2 element; bit 0 of vs2 contributes nothing.
- R4: In the vector-scalar form every element uses the low SEW bits of `in_scalar` as the other operand; in the vector-vector form element i uses element i of `in_vs1`.
- R5: With vm=1 every element below `in_vl` is active; with vm=0 element i is active only when `in_mask[i]` is 1.
- R6: An inactive element, including any element with index at or above `in_vl`, outputs its `in_old_vd` value and has its `out_elem_we` bit clear.
- R7: An illegal instruction raises `out_illegal`, clears `out_we` and all `out_elem_we` bits, and returns `in_old_vd` unchanged.
- R8: After reset `out_valid` is 0; an accepted input appears on the outputs with `out_valid` high on the clock edge that accepts it.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs stay stable.
- R10: `out_we` is 1 exactly when the instruction is legal and at least one element is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_instr | input | 32 | Instruction word |
| in_vs2 | input | N*SEW | First source vector |
| in_vs1 | input | N*SEW | Second source vector (vector-vector form) |
| in_scalar | input | XLEN | Scalar register value (vector-scalar form) |
| in_mask | input | N | Per-element mask bits |
| in_vl | input | clog2(N+1) | Active vector length |
| in_old_vd | input | N*SEW | Previous destination vector |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream can take the result |
| out_vd | output | N*SEW | New destination vector |
| out_elem_we | output | N | Per-element write strobes |
| out_we | output | 1 | Destination write enable |
| out_illegal | output | 1 | Instruction did not decode |

## Verification
The assertions check the handshake on every cycle: an accepted beat becomes valid, and a stalled beat holds steady. They also check that an illegal beat never carries a write, that no strobe lands at or past the active length, and that a lane whose multiplier is zero or one gives the trivial product. Only the bench scenarios can show that the products themselves are correct. Those scenarios compare each output against a bit-by-bit reference over zero, all-ones and single-bit operands, and they exercise scalar broadcast, alternating mask patterns and undisturbed old values.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;
  localparam logic [6:0] OPC_VEC   = 7'b1010111;
  localparam logic [5:0] F6_LOW    = 6'b001100;
  localparam logic [5:0] F6_HIGH   = 6'b001101;
  localparam logic [2:0] F3_VECVEC = 3'b010;
  localparam logic [2:0] F3_VECSCL = 3'b110;

  typedef struct packed {
    logic legal;
    logic high;
    logic use_scalar;
    logic unmasked;
  } op_dec_t;
endpackage

// File: rtl/vclmul_decode.sv
module vclmul_decode
  import vclmul_pkg::*;
(
  input  logic [31:0] instr,
  output op_dec_t     dec
);
  logic [6:0] opc;
  logic [5:0] f6;
  logic [2:0] f3;
  logic       f6_ok;
  logic       f3_ok;

  assign opc   = instr[6:0];
  assign f6    = instr[31:26];
  assign f3    = instr[14:12];
  assign f6_ok = (f6 == F6_LOW) || (f6 == F6_HIGH);
  assign f3_ok = (f3 == F3_VECVEC) || (f3 == F3_VECSCL);

  always_comb begin
    dec.legal      = (opc == OPC_VEC) && f6_ok && f3_ok;
    dec.high       = (f6 == F6_HIGH);
    dec.use_scalar = (f3 == F3_VECSCL);
    dec.unmasked   = instr[25];
  end
endmodule

// File: rtl/vclmul_lane.sv
module vclmul_lane #(
  parameter int SEW = 64
) (
  input  logic [SEW-1:0] op_a,
  input  logic [SEW-1:0] op_b,
  input  logic           take_high,
  output logic [SEW-1:0] res
);
  localparam int PW = 2 * SEW;

  logic [PW-1:0] prod;

  always_comb begin
    prod = '0;
    for (int n = 0; n < SEW; n++) begin
      if (op_a[n]) prod = prod ^ ({{SEW{1'b0}}, op_b} << n);
    end
  end

  assign res = take_high ? prod[PW-1:SEW] : prod[SEW-1:0];

  always_comb begin
    if (op_a == '0) begin
      p_zero_mult_r2: assert (res == '0);
    end
    if (op_a == {{(SEW-1){1'b0}}, 1'b1}) begin
      p_unit_mult_r3: assert (res == (take_high ? '0 : op_b));
    end
  end
endmodule

// File: rtl/vclmul_outreg.sv
module vclmul_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) dat_q <= in_data;
  end

  p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vclmul_unit.sv
module vclmul_unit
  import vclmul_pkg::*;
#(
  parameter int N    = 4,
  parameter int SEW  = 64,
  parameter int XLEN = 64,
  localparam int VW  = N * SEW,
  localparam int VLW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [VW-1:0]   in_vs2,
  input  logic [VW-1:0]   in_vs1,
  input  logic [XLEN-1:0] in_scalar,
  input  logic [N-1:0]    in_mask,
  input  logic [VLW-1:0]  in_vl,
  input  logic [VW-1:0]   in_old_vd,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VW-1:0]   out_vd,
  output logic [N-1:0]    out_elem_we,
  output logic            out_we,
  output logic            out_illegal
);
  localparam int DW = VW + N + 2;

  op_dec_t        dec;
  logic [N-1:0]   len_keep;
  logic [N-1:0]   elem_act;
  logic [VW-1:0]  new_vd;
  logic [DW-1:0]  pack_in;
  logic [DW-1:0]  pack_out;

  vclmul_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [SEW-1:0] b_opnd;
    logic [SEW-1:0] lane_res;

    assign b_opnd      = dec.use_scalar ? in_scalar[SEW-1:0] : in_vs1[i*SEW +: SEW];
    assign len_keep[i] = (32'(in_vl) > 32'(i));
    assign elem_act[i] = dec.legal && len_keep[i] && (dec.unmasked || in_mask[i]);

    vclmul_lane #(.SEW(SEW)) u_lane (
      .op_a      (in_vs2[i*SEW +: SEW]),
      .op_b      (b_opnd),
      .take_high (dec.high),
      .res       (lane_res)
    );

    assign new_vd[i*SEW +: SEW] = elem_act[i] ? lane_res : in_old_vd[i*SEW +: SEW];
  end

  assign pack_in = {new_vd, elem_act, dec.legal && (|elem_act), !dec.legal};

  vclmul_outreg #(.W(DW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pack_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pack_out)
  );

  assign out_vd      = pack_out[DW-1 -: VW];
  assign out_elem_we = pack_out[N+1:2];
  assign out_we      = pack_out[1];
  assign out_illegal = pack_out[0];

  p_illegal_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_we && (out_elem_we == '0)));

  p_no_write_past_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_elem_we & ~$past(len_keep)) == '0));

  p_we_matches_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_we == (|out_elem_we)));
endmodule

// File: tb/vclmul_unit_bench.sv
`timescale 1ns/1ps
module vclmul_unit_bench;
  localparam int N   = 4;
  localparam int SEW = 64;
  localparam int VW  = N * SEW;
  localparam int VLW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_instr = '0;
  logic [VW-1:0] in_vs2 = '0, in_vs1 = '0, in_old_vd = '0;
  logic [63:0] in_scalar = '0;
  logic [N-1:0] in_mask = '0;
  logic [VLW-1:0] in_vl = '0;
  logic out_valid, out_ready = 1'b1;
  logic [VW-1:0] out_vd;
  logic [N-1:0] out_elem_we;
  logic out_we, out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vclmul_unit u_vclmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_vs2(in_vs2), .in_vs1(in_vs1), .in_scalar(in_scalar),
    .in_mask(in_mask), .in_vl(in_vl), .in_old_vd(in_old_vd),
    .out_valid(out_valid), .out_ready(out_ready), .out_vd(out_vd),
    .out_elem_we(out_elem_we), .out_we(out_we), .out_illegal(out_illegal)
  );

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_clmul(logic [63:0] a, logic [63:0] b);
    logic [127:0] r = '0;
    for (int k = 0; k < 128; k++) begin
      logic bt = 1'b0;
      for (int i = 0; i < 64; i++) begin
        int j = k - i;
        if (j >= 0 && j < 64) bt = bt ^ (a[i] & b[j]);
      end
      r[k] = bt;
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [2:0] f3, logic [6:0] opc);
    return {f6, vm, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  // expected outcome computed from R1..R7, R10
  task automatic expect_of(output logic [VW-1:0] evd, output logic [N-1:0] ewe,
                           output logic ewe1, output logic eill);
    logic ok;
    ok = (in_instr[6:0] == 7'b1010111) &&
         (in_instr[31:26] == 6'b001100 || in_instr[31:26] == 6'b001101) &&
         (in_instr[14:12] == 3'b010 || in_instr[14:12] == 3'b110);
    eill = !ok;
    evd = in_old_vd;
    ewe = '0;
    for (int i = 0; i < N; i++) begin
      logic [63:0] b;
      logic [127:0] p;
      if (ok && i < int'(in_vl) && (in_instr[25] || in_mask[i])) begin
        b = (in_instr[14:12] == 3'b110) ? in_scalar : in_vs1[i*SEW +: SEW];
        p = ref_clmul(in_vs2[i*SEW +: SEW], b);
        evd[i*SEW +: SEW] = (in_instr[31:26] == 6'b001101) ? p[127:64] : p[63:0];
        ewe[i] = 1'b1;
      end
    end
    ewe1 = ok && (ewe != '0);
  endtask

  task automatic run_op(string req, logic [31:0] ins, logic [VW-1:0] a, logic [VW-1:0] b,
                        logic [63:0] sc, logic [N-1:0] m, int vl, logic [VW-1:0] old);
    logic [VW-1:0] evd; logic [N-1:0] ewe; logic ewe1, eill;
    @(negedge clk);
    in_instr = ins; in_vs2 = a; in_vs1 = b; in_scalar = sc; in_mask = m;
    in_vl = VLW'(vl); in_old_vd = old; in_valid = 1'b1;
    expect_of(evd, ewe, ewe1, eill);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R8 valid"}, VW'(out_valid), VW'(1));
    chk({req, " vd"}, out_vd, evd);
    chk({req, " R6 strobes"}, VW'(out_elem_we), VW'(ewe));
    chk({req, " R10 we"}, VW'(out_we), VW'(ewe1));
    chk({req, " R7 illegal"}, VW'(out_illegal), VW'(eill));
  endtask

  localparam logic [VW-1:0] PAT_A = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210,
                                     64'hA5A5A5A55A5A5A5A, 64'h00000000DEADBEEF};
  localparam logic [VW-1:0] PAT_B = {64'h13579BDF2468ACE0, 64'h8000000000000001,
                                     64'hFFFF0000FFFF0000, 64'hCAFEBABE12345678};
  localparam logic [VW-1:0] OLD   = {4{64'h5555AAAA5555AAAA}};

  task automatic t_reset();
    chk("R8 reset valid", VW'(out_valid), VW'(0));
    chk("R9 reset ready", VW'(in_ready), VW'(1));
  endtask

  task automatic t_zero_ones();
    run_op("R2 zero lo", mk(6'b001100, 1, 3'b010, 7'b1010111), '0, PAT_B, 0, '0, 4, OLD);
    run_op("R3 zero hi", mk(6'b001101, 1, 3'b010, 7'b1010111), PAT_A, '0, 0, '0, 4, OLD);
    run_op("R2 ones lo", mk(6'b001100, 1, 3'b010, 7'b1010111), '1, '1, 0, '0, 4, OLD);
    run_op("R3 ones hi", mk(6'b001101, 1, 3'b010, 7'b1010111), '1, '1, 0, '0, 4, OLD);
  endtask

  task automatic t_single_bits();
    logic [VW-1:0] b0 = {4{64'h1}};
    logic [VW-1:0] b63 = {4{64'h8000000000000000}};
    run_op("R3 bit0 hi", mk(6'b001101, 1, 3'b010, 7'b1010111), b0, PAT_B, 0, '0, 4, OLD);
    run_op("R2 bit0 lo", mk(6'b001100, 1, 3'b010, 7'b1010111), b0, PAT_B, 0, '0, 4, OLD);
    run_op("R3 bit63 hi", mk(6'b001101, 1, 3'b010, 7'b1010111), b63, PAT_B, 0, '0, 4, OLD);
    run_op("R2 bit63 lo", mk(6'b001100, 1, 3'b010, 7'b1010111), PAT_A, b63, 0, '0, 4, OLD);
  endtask

  task automatic t_mixed_vv();
    run_op("R2 mixed lo", mk(6'b001100, 1, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, '0, 4, OLD);
    run_op("R3 mixed hi", mk(6'b001101, 1, 3'b010, 7'b1010111), PAT_B, PAT_A, 0, '0, 4, OLD);
  endtask

  task automatic t_scalar();
    run_op("R4 vx lo", mk(6'b001100, 1, 3'b110, 7'b1010111), PAT_A, PAT_B,
           64'h9E3779B97F4A7C15, '0, 4, OLD);
    run_op("R4 vx hi", mk(6'b001101, 1, 3'b110, 7'b1010111), PAT_A, PAT_B,
           64'hF0F0F0F00F0F0F0F, '0, 4, OLD);
  endtask

  task automatic t_masks();
    run_op("R5 vm0 mask0101", mk(6'b001100, 0, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, 4'b0101, 4, OLD);
    run_op("R5 vm0 mask1010", mk(6'b001101, 0, 3'b110, 7'b1010111), PAT_A, PAT_B,
           64'h123456789, 4'b1010, 4, OLD);
    run_op("R5 vm1 mask ignored", mk(6'b001100, 1, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, 4'b0000, 4, OLD);
    run_op("R6 vm0 mask none", mk(6'b001101, 0, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, 4'b0000, 4, OLD);
  endtask

  task automatic t_length();
    run_op("R6 vl2", mk(6'b001100, 1, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, '0, 2, OLD);
    run_op("R6 vl0", mk(6'b001101, 1, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, '0, 0, OLD);
    run_op("R6 vl3 vm0", mk(6'b001100, 0, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, 4'b1111, 3, OLD);
  endtask

  task automatic t_illegal();
    run_op("R1 bad opcode", mk(6'b001100, 1, 3'b010, 7'b1010011), PAT_A, PAT_B, 0, '0, 4, OLD);
    run_op("R1 bad funct6", mk(6'b001110, 1, 3'b010, 7'b1010111), PAT_A, PAT_B, 0, '0, 4, OLD);
    run_op("R1 bad funct3", mk(6'b001101, 1, 3'b111, 7'b1010111), PAT_A, PAT_B, 0, '0, 4, OLD);
  endtask

  task automatic t_backpressure();
    logic [VW-1:0] evd1, evd2; logic [N-1:0] w; logic w1, il;
    @(negedge clk);
    out_ready = 1'b0;
    in_instr = mk(6'b001100, 1, 3'b010, 7'b1010111); in_vs2 = PAT_A; in_vs1 = PAT_B;
    in_mask = '0; in_vl = VLW'(4); in_old_vd = OLD; in_valid = 1'b1;
    expect_of(evd1, w, w1, il);
    @(negedge clk);
    chk("R9 stalled ready low", VW'(in_ready), VW'(0));
    in_instr = mk(6'b001101, 1, 3'b010, 7'b1010111);
    expect_of(evd2, w, w1, il);
    @(negedge clk);
    chk("R9 held valid", VW'(out_valid), VW'(1));
    chk("R9 held data", out_vd, evd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second beat", out_vd, evd2);
    chk("R8 second valid", VW'(out_valid), VW'(1));
    @(negedge clk);
    chk("R8 drained", VW'(out_valid), VW'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero_ones();
    t_single_bits();
    t_mixed_vv();
    t_scalar();
    t_masks();
    t_length();
    t_illegal();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule